// File: doc/BRIEF.md
# Roll-Mode Sample Memory Pointer Controller

This block steers the write pointer of a circular analog sample memory of 13 cells, each cell holding a high-gain and a low-gain sample taken together. In roll mode it selects one cell per 25 ns bunch crossing, one cycle of a 40 MHz clock. The cells are overwritten in a ring, and cell 12 is followed by cell 0. An external trigger stops the writing. It latches the index of the last cell written, which is the origin for looking back during readout, and it fires a one-cycle start-of-conversion pulse. The block stays busy until a release strobe from the readout. It then resumes writing at the cell after the frozen one.

In custom mode nothing is written on its own. Each trigger captures exactly one cell, the one at the current pointer, and then runs the same freeze, conversion and release sequence. The analog cells and the converter sit outside this block. The block drives only the per-cell hold enables, the frozen pointer, the busy flag and the conversion pulse.

The controller is a five-state machine:
- ROLL writes the pointer cell on every cycle.
- ARMED is idle in custom mode.
- CAPTURE writes one commanded cell.
- CONVSTART gives the conversion pulse.
- WAIT is busy until release.

Its transitions are:
- ROLL→CONVSTART on a trigger.
- ROLL→ARMED when custom mode is selected.
- ARMED→CAPTURE on a trigger.
- ARMED→ROLL when custom mode is cleared.
- CAPTURE→CONVSTART always.
- CONVSTART→WAIT always.
- WAIT→ROLL or WAIT→ARMED on release, chosen by the mode input.

Top module: `rollmem_ptr_ctrl`

## Requirements
- R1: The reset is synchronous and active high. After it: busy=0, conv_start=0, frozen_ptr=0, and the controller is in ROLL with hold bit 0 set (cell 0 being written).
- R2: In roll mode with no trigger, exactly one hold bit is set per cycle (bit i means cell i). The set bit moves up by one each clock, and cell 12 is followed by cell 0.
- R3: hold_hg and hold_lg are equal in every cycle.
- R4: A trigger sampled in ROLL latches into frozen_ptr the cell held in that cycle. In the next cycle busy=1, all holds are 0 and conv_start=1. conv_start lasts exactly one cycle.
- R5: While busy, triggers are ignored: no hold bit is set, frozen_ptr does not change and conv_start does not pulse again.
- R6: Release is accepted only in WAIT, the busy cycles after the conv_start cycle. It is ignored in every other state. In the cycle after an accepted release, busy=0. If custom_mode=0, writing resumes at cell (frozen_ptr+1) mod 13.
- R7: In custom mode with no trigger (ARMED), all hold bits stay 0 and busy=0.
- R8: A trigger sampled in ARMED gives, in the next cycle, one hold bit for the current pointer cell and busy=1, for one cycle only. The cycle after that has conv_start=1 and frozen_ptr equal to that cell.
- R9: After a release in custom mode, the next trigger captures cell (frozen_ptr+1) mod 13.
- R10: custom_mode is sampled on each clock edge outside busy. A change from roll to custom stops writing from the next cycle. A change from custom to roll restarts writing at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | External trigger |
| custom_mode | input | 1 | 1 = custom (trigger-commanded) capture, 0 = roll |
| release_in | input | 1 | Readout-done strobe |
| hold_hg | output | NUM_CELLS | Per-cell write enable, high-gain row |
| hold_lg | output | NUM_CELLS | Per-cell write enable, low-gain row |
| frozen_ptr | output | PTR_W | Cell index latched at the last freeze |
| busy | output | 1 | Conversion or readout in progress |
| conv_start | output | 1 | One-cycle start-of-conversion pulse |

## Verification
Every state change lands one edge after the inputs are sampled. Holds, busy and conv_start are decoded from the state register, and frozen_ptr comes from its own register. So every result of an input applied before edge k is visible right after edge k. In a custom capture, conv_start and the new frozen_ptr follow one edge later. The bench drives inputs and compares all outputs 1 ns after each rising edge, against a cycle model built from the requirements. It sweeps a freeze from each of the 13 cells and runs a long pseudo-random input stream.

// File: rtl/rollmem_pkg.sv
`timescale 1ns/1ps
package rollmem_pkg;
    typedef enum logic [2:0] {
        ST_ROLL      = 3'd0,
        ST_ARMED     = 3'd1,
        ST_CAPTURE   = 3'd2,
        ST_CONVSTART = 3'd3,
        ST_WAIT      = 3'd4
    } ctl_state_t;
endpackage

// File: rtl/rollmem_ptr_ring.sv
`timescale 1ns/1ps
// Write pointer wrapping modulo NUM_CELLS, plus the frozen (lookback) index.
module rollmem_ptr_ring #(
    parameter int NUM_CELLS = 13,
    parameter int PTR_W     = $clog2(NUM_CELLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             latch,
    input  logic             resume,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] frozen_ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CELLS - 1);

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            frozen_ptr <= '0;
        end else begin
            if (latch)
                frozen_ptr <= wr_ptr;
            if (resume)
                wr_ptr <= step_ptr(frozen_ptr);
            else if (advance)
                wr_ptr <= step_ptr(wr_ptr);
        end
    end

    // R2: the pointer wraps from the last cell back to cell 0
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (advance && !resume && wr_ptr == LAST) |=> (wr_ptr == '0));

    // R2: the pointer never leaves the cell range
    p_range_r2: assert property (@(posedge clk) disable iff (rst)
        wr_ptr <= LAST);

    // R5: the frozen index only moves on a latch
    p_frozen_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(frozen_ptr));
endmodule

// File: rtl/rollmem_cell_decoder.sv
`timescale 1ns/1ps
// One-hot hold enables for one row of cells.
module rollmem_cell_decoder #(
    parameter int NUM_CELLS = 13,
    parameter int PTR_W     = $clog2(NUM_CELLS)
) (
    input  logic                 en,
    input  logic [PTR_W-1:0]     ptr,
    output logic [NUM_CELLS-1:0] cells
);
    for (genvar g = 0; g < NUM_CELLS; g++) begin : g_cell
        assign cells[g] = en && (ptr == PTR_W'(g));
    end

    always_comb begin
        p_onehot_r2: assert ($onehot0(cells));
    end
endmodule

// File: rtl/rollmem_seq_fsm.sv
`timescale 1ns/1ps
// Sequencer: roll / armed / capture / conversion start / wait-for-release.
module rollmem_seq_fsm
    import rollmem_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    input  logic custom_mode,
    input  logic release_in,
    output logic write_en,
    output logic advance,
    output logic latch,
    output logic resume,
    output logic busy,
    output logic conv_start
);
    ctl_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_ROLL;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_ROLL: begin
                if (trig_in)
                    state_nxt = ST_CONVSTART;
                else if (custom_mode)
                    state_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (trig_in)
                    state_nxt = ST_CAPTURE;
                else if (!custom_mode)
                    state_nxt = ST_ROLL;
            end
            ST_CAPTURE:   state_nxt = ST_CONVSTART;
            ST_CONVSTART: state_nxt = ST_WAIT;
            ST_WAIT: begin
                if (release_in)
                    state_nxt = custom_mode ? ST_ARMED : ST_ROLL;
            end
            default:      state_nxt = ST_ROLL;
        endcase
    end

    always_comb begin
        write_en   = 1'b0;
        advance    = 1'b0;
        latch      = 1'b0;
        resume     = 1'b0;
        busy       = 1'b0;
        conv_start = 1'b0;
        unique case (state)
            ST_ROLL: begin
                write_en = 1'b1;
                advance  = !trig_in;
                latch    = trig_in;
            end
            ST_ARMED: ;
            ST_CAPTURE: begin
                write_en = 1'b1;
                latch    = 1'b1;
                busy     = 1'b1;
            end
            ST_CONVSTART: begin
                busy       = 1'b1;
                conv_start = 1'b1;
            end
            ST_WAIT: begin
                busy   = 1'b1;
                resume = release_in;
            end
            default: ;
        endcase
    end

    // R4: the conversion pulse is one cycle long
    p_conv_once_r4: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R5: only a release leaves WAIT; triggers do nothing there
    p_wait_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !release_in) |=> (state == ST_WAIT));

    // R8: a custom capture occupies a single cycle, then conversion starts
    p_capture_one_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAPTURE) |=> (state == ST_CONVSTART));

    // R7: ARMED stays idle without a trigger while custom mode holds
    p_armed_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && !trig_in && custom_mode) |=> (state == ST_ARMED && !busy));
endmodule

// File: rtl/rollmem_ptr_ctrl.sv
`timescale 1ns/1ps
// Top: roll-mode sample-memory pointer controller.
module rollmem_ptr_ctrl #(
    parameter int NUM_CELLS = 13,
    parameter int PTR_W     = $clog2(NUM_CELLS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_in,
    input  logic                 custom_mode,
    input  logic                 release_in,
    output logic [NUM_CELLS-1:0] hold_hg,
    output logic [NUM_CELLS-1:0] hold_lg,
    output logic [PTR_W-1:0]     frozen_ptr,
    output logic                 busy,
    output logic                 conv_start
);
    logic             write_en, advance, latch, resume;
    logic [PTR_W-1:0] wr_ptr;

    rollmem_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .trig_in     (trig_in),
        .custom_mode (custom_mode),
        .release_in  (release_in),
        .write_en    (write_en),
        .advance     (advance),
        .latch       (latch),
        .resume      (resume),
        .busy        (busy),
        .conv_start  (conv_start)
    );

    rollmem_ptr_ring #(.NUM_CELLS(NUM_CELLS), .PTR_W(PTR_W)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .latch      (latch),
        .resume     (resume),
        .wr_ptr     (wr_ptr),
        .frozen_ptr (frozen_ptr)
    );

    rollmem_cell_decoder #(.NUM_CELLS(NUM_CELLS), .PTR_W(PTR_W)) u_dec_hg (
        .en    (write_en),
        .ptr   (wr_ptr),
        .cells (hold_hg)
    );

    rollmem_cell_decoder #(.NUM_CELLS(NUM_CELLS), .PTR_W(PTR_W)) u_dec_lg (
        .en    (write_en),
        .ptr   (wr_ptr),
        .cells (hold_lg)
    );

    // R3: both gain rows are held together
    p_rows_match_r3: assert property (@(posedge clk) disable iff (rst)
        hold_hg == hold_lg);

    // R4: a roll-mode trigger freezes the written cell and starts conversion
    p_roll_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && (|hold_hg) && trig_in) |=>
            (busy && conv_start && hold_hg == '0 && frozen_ptr == $past(wr_ptr)));

    // R5: nothing is written while the conversion pulse is out
    p_quiet_conv_r5: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (hold_hg == '0 && busy));

    // R6: a release in WAIT clears busy on the next cycle
    p_release_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_start && hold_hg == '0 && release_in) |=> !busy);
endmodule

// File: tb/rollmem_ptr_ctrl_tb.sv
`timescale 1ns/1ps
module rollmem_ptr_ctrl_tb_top;
    localparam int N  = 13;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_in = 1'b0;
    logic          custom_mode = 1'b0;
    logic          release_in = 1'b0;
    logic [N-1:0]  hold_hg, hold_lg;
    logic [PW-1:0] frozen_ptr;
    logic          busy, conv_start;

    always #2.5 clk = ~clk;

    rollmem_ptr_ctrl #(.NUM_CELLS(N), .PTR_W(PW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .trig_in     (trig_in),
        .custom_mode (custom_mode),
        .release_in  (release_in),
        .hold_hg     (hold_hg),
        .hold_lg     (hold_lg),
        .frozen_ptr  (frozen_ptr),
        .busy        (busy),
        .conv_start  (conv_start)
    );

    // model: 0 roll, 1 armed, 2 capture, 3 conversion start, 4 wait
    int m_st, m_wp, m_fr;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] cell_bit(input int c);
        return N'(1) << c;
    endfunction

    task automatic compare(input string tag);
        logic [N-1:0] eh;
        string tg;
        eh = (m_st == 0 || m_st == 2) ? cell_bit(m_wp) : '0;
        if (tag != "") tg = tag;
        else case (m_st)
            0: tg = "R2";
            1: tg = "R7";
            2: tg = "R8";
            3: tg = "R4";
            default: tg = "R5";
        endcase
        chk(hold_hg == eh, tg, "hold_hg", longint'(hold_hg), longint'(eh));
        chk(hold_lg == hold_hg, "R3", "hold_lg", longint'(hold_lg), longint'(hold_hg));
        chk(busy == (m_st >= 2), tg, "busy", longint'(busy), longint'(m_st >= 2));
        chk(conv_start == (m_st == 3), tg, "conv_start", longint'(conv_start), longint'(m_st == 3));
        chk(int'(frozen_ptr) == m_fr, tg, "frozen_ptr", longint'(frozen_ptr), longint'(m_fr));
    endtask

    task automatic cyc(input logic t, input logic m, input logic rl, input string tag);
        trig_in = t; custom_mode = m; release_in = rl;
        @(posedge clk);
        case (m_st)
            0: if (t) begin m_fr = m_wp; m_st = 3; end
               else begin m_wp = (m_wp + 1) % N; if (m) m_st = 1; end
            1: if (t) m_st = 2; else if (!m) m_st = 0;
            2: begin m_fr = m_wp; m_st = 3; end
            3: m_st = 4;
            default: if (rl) begin m_wp = (m_fr + 1) % N; m_st = m ? 1 : 0; end
        endcase
        #1;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; trig_in = 1'b0; custom_mode = 1'b0; release_in = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        m_st = 0; m_wp = 0; m_fr = 0;
        compare("R1");
        chk(hold_hg == N'(1), "R1", "reset hold", longint'(hold_hg), 1);
    endtask

    initial begin
        do_reset();

        // R2: long roll run wrapping twice
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 1'b0, "R2");

        // R4/R5/R6: freeze from every cell
        for (int s = 0; s < N; s++) begin
            do_reset();
            for (int i = 0; i < s; i++) cyc(1'b0, 1'b0, 1'b0, "");
            chk(hold_hg == cell_bit(s), "R2", "pre-trigger hold", longint'(hold_hg), longint'(cell_bit(s)));
            cyc(1'b1, 1'b0, 1'b0, "R4");
            chk(int'(frozen_ptr) == s, "R4", "frozen cell", longint'(frozen_ptr), longint'(s));
            cyc(1'b1, 1'b0, 1'b1, "R6");        // release in the pulse cycle is ignored
            chk(busy == 1'b1, "R6", "busy after early release", longint'(busy), 1);
            cyc(1'b1, 1'b0, 1'b0, "R5");
            cyc(1'b1, 1'b0, 1'b0, "R5");
            cyc(1'b0, 1'b0, 1'b1, "R6");
            chk(hold_hg == cell_bit((s + 1) % N), "R6", "resume cell",
                longint'(hold_hg), longint'(cell_bit((s + 1) % N)));
        end

        // R7..R10: custom mode
        do_reset();
        cyc(1'b0, 1'b1, 1'b0, "R10");
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, "R7");
        cyc(1'b1, 1'b1, 1'b0, "R8");
        chk(hold_hg == cell_bit(1), "R8", "captured cell", longint'(hold_hg), longint'(cell_bit(1)));
        cyc(1'b1, 1'b1, 1'b0, "R8");
        chk(int'(frozen_ptr) == 1, "R8", "frozen custom", longint'(frozen_ptr), 1);
        cyc(1'b0, 1'b1, 1'b0, "R5");
        cyc(1'b0, 1'b1, 1'b1, "R9");
        cyc(1'b1, 1'b1, 1'b0, "R9");
        chk(hold_hg == cell_bit(2), "R9", "next captured cell", longint'(hold_hg), longint'(cell_bit(2)));
        cyc(1'b0, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b1, 1'b0, "");
        cyc(1'b0, 1'b0, 1'b1, "R10");
        chk(hold_hg == cell_bit(3), "R10", "roll after custom release", longint'(hold_hg), longint'(cell_bit(3)));
        cyc(1'b0, 1'b1, 1'b0, "R10");
        chk(hold_hg == '0, "R10", "custom stops writing", longint'(hold_hg), 0);
        cyc(1'b0, 1'b0, 1'b0, "R10");
        chk(hold_hg == cell_bit(4), "R10", "roll restart cell", longint'(hold_hg), longint'(cell_bit(4)));

        // pseudo-random sweep
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[2:0] == 3'd0, (lfsr[11:8] == 4'd0) ? ~custom_mode : custom_mode,
                lfsr[5:4] == 2'd0, "");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule